// File: doc/BRIEF.md
# Calendar Tick Prescaler

This block divides the real-time-clock kernel clock down to the once-per-second calendar tick. The division happens in two cascaded down-counting stages. A short first stage strobes `coarse_tick` once every A+1 kernel cycles. A wider second stage advances only on that strobe and raises `cal_tick` once every S+1 first-stage strobes. The full period is therefore (A+1)×(S+1) kernel cycles. Software chooses A and S. The block holds both values in one packed configuration word: S in bits [14:0] and A in bits [22:16]. All other bits always read as zero.

The configuration word can be changed only while the calendar is in its setup mode, which `setup_ack` reports. While `setup_ack` is high, both stages stop. They load the current configuration, including a value written in that same cycle, so the first tick after setup ends comes a whole period later. A write while `setup_ack` is low is dropped. The block has no streaming data path, so every pin is plain control or status and there is no back-pressure.

Top module: `cal_tick_prescaler`

## Requirements
- R1: After reset `cfg_rd` reads 32'h007F_00FF (A=127, S=255), and the first `cal_tick` follows 32768 cycles after reset is released.
- R2: A write (`cfg_wr` high) with `setup_ack` high updates `cfg_rd` from the next cycle on. A write with `setup_ack` low leaves `cfg_rd` unchanged.
- R3: Bits 15 and 31:23 of `cfg_rd` always read zero, whatever was written to them.
- R4: While `setup_ack` is high, `coarse_tick` and `cal_tick` stay low and both stages hold their loaded values.
- R5: Counting k from 0 at the first cycle with `setup_ack` low, `coarse_tick` is high exactly when k mod (A+1) equals A.
- R6: `cal_tick` is high exactly when k mod ((A+1)(S+1)) equals (A+1)(S+1)−1. It is always high together with `coarse_tick`.
- R7: `fine_count` equals S − (floor(k/(A+1)) mod (S+1)). It never exceeds S outside setup.
- R8: With A=0, `coarse_tick` is high on every cycle outside setup, and `cal_tick` has period S+1.
- R9: A write made in the last setup cycle governs the first period after setup ends, which lasts exactly (A+1)(S+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_ack | input | 1 | Setup mode acknowledged: stops the counters and allows writes |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Write data: S in [14:0], A in [22:16] |
| cfg_rd | output | 32 | Current configuration word, with reserved bits reading zero |
| coarse_tick | output | 1 | One-cycle strobe from the first stage |
| cal_tick | output | 1 | One-cycle calendar tick |
| fine_count | output | 15 | Current value of the second stage |

## Verification
The bench builds the block with its default parameters: a 7-bit first stage, a 15-bit second stage and reset values 127 and 255. With these values the full 32768-cycle default period after reset fits within the run. Small reload values written at run time give short periods. These include A=0, where the first stage strobes on every cycle, and S=0, where every coarse strobe is also a calendar tick. Many wraps of both stages can then be compared cycle by cycle against a model built on arithmetic over the elapsed count.

// File: rtl/cal_tick_pkg.sv
package cal_tick_pkg;
  localparam int CFG_W      = 32;
  localparam int COARSE_W   = 7;
  localparam int FINE_W     = 15;
  localparam int COARSE_LSB = 16;
  localparam int COARSE_RST = 127;
  localparam int FINE_RST   = 255;
endpackage

// File: rtl/cal_tick_cfg.sv
module cal_tick_cfg #(
  parameter int CFG_W      = 32,
  parameter int COARSE_W   = 7,
  parameter int FINE_W     = 15,
  parameter int COARSE_LSB = 16,
  parameter int COARSE_RST = 127,
  parameter int FINE_RST   = 255
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                setup_ack,
  input  logic                cfg_wr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_q,
  output logic [COARSE_W-1:0] coarse_nxt,
  output logic [FINE_W-1:0]   fine_nxt
);
  localparam int COARSE_MSB = COARSE_LSB + COARSE_W - 1;

  logic [COARSE_W-1:0] coarse_q;
  logic [FINE_W-1:0]   fine_q;
  logic                take;

  assign take = setup_ack && cfg_wr;

  always_comb begin
    coarse_nxt = coarse_q;
    fine_nxt   = fine_q;
    if (take) begin
      coarse_nxt = cfg_wdata[COARSE_MSB:COARSE_LSB];
      fine_nxt   = cfg_wdata[FINE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse_q <= COARSE_W'(COARSE_RST);
      fine_q   <= FINE_W'(FINE_RST);
    end else begin
      coarse_q <= coarse_nxt;
      fine_q   <= fine_nxt;
    end
  end

  always_comb begin
    cfg_q = '0;
    cfg_q[FINE_W-1:0]            = fine_q;
    cfg_q[COARSE_MSB:COARSE_LSB] = coarse_q;
  end
endmodule

// File: rtl/cal_tick_stage.sv
module cal_tick_stage #(
  parameter int W       = 7,
  parameter int RST_VAL = 127
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         step,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic at_zero;

  assign at_zero = (cnt == '0);
  assign wrap    = step && at_zero && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= W'(RST_VAL);
    else if (hold)
      cnt <= reload;
    else if (step)
      cnt <= at_zero ? reload : cnt - 1'b1;
  end
endmodule

// File: rtl/cal_tick_prescaler.sv
module cal_tick_prescaler
  import cal_tick_pkg::*;
#(
  parameter int P_CFG_W      = CFG_W,
  parameter int P_COARSE_W   = COARSE_W,
  parameter int P_FINE_W     = FINE_W,
  parameter int P_COARSE_LSB = COARSE_LSB,
  parameter int P_COARSE_RST = COARSE_RST,
  parameter int P_FINE_RST   = FINE_RST
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 setup_ack,
  input  logic                 cfg_wr,
  input  logic [P_CFG_W-1:0]   cfg_wdata,
  output logic [P_CFG_W-1:0]   cfg_rd,
  output logic                 coarse_tick,
  output logic                 cal_tick,
  output logic [P_FINE_W-1:0]  fine_count
);
  logic [P_COARSE_W-1:0] coarse_nxt;
  logic [P_FINE_W-1:0]   fine_nxt;
  logic [P_COARSE_W-1:0] coarse_cnt;
  logic                  coarse_wrap;
  logic                  fine_wrap;

  cal_tick_cfg #(
    .CFG_W(P_CFG_W), .COARSE_W(P_COARSE_W), .FINE_W(P_FINE_W),
    .COARSE_LSB(P_COARSE_LSB), .COARSE_RST(P_COARSE_RST), .FINE_RST(P_FINE_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .setup_ack(setup_ack), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_q(cfg_rd), .coarse_nxt(coarse_nxt), .fine_nxt(fine_nxt)
  );

  cal_tick_stage #(.W(P_COARSE_W), .RST_VAL(P_COARSE_RST)) u_coarse (
    .clk(clk), .rst_n(rst_n), .hold(setup_ack), .step(1'b1),
    .reload(coarse_nxt), .cnt(coarse_cnt), .wrap(coarse_wrap)
  );

  cal_tick_stage #(.W(P_FINE_W), .RST_VAL(P_FINE_RST)) u_fine (
    .clk(clk), .rst_n(rst_n), .hold(setup_ack), .step(coarse_wrap),
    .reload(fine_nxt), .cnt(fine_count), .wrap(fine_wrap)
  );

  assign coarse_tick = coarse_wrap;
  assign cal_tick    = fine_wrap;
endmodule

// File: rtl/cal_tick_prescaler_chk.sv
module cal_tick_prescaler_chk #(
  parameter int P_CFG_W      = 32,
  parameter int P_FINE_W     = 15,
  parameter int P_COARSE_W   = 7,
  parameter int P_COARSE_LSB = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                setup_ack,
  input logic                cfg_wr,
  input logic [P_CFG_W-1:0]  cfg_rd,
  input logic                coarse_tick,
  input logic                cal_tick,
  input logic [P_FINE_W-1:0] fine_count
);
  localparam int CMSB = P_COARSE_LSB + P_COARSE_W - 1;

  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_ack |=> $stable(cfg_rd)) else $error("write outside setup"); // R2

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd[P_FINE_W] == 1'b0) && (cfg_rd[P_CFG_W-1:CMSB+1] == '0)) else $error("reserved bits"); // R3

  AST_QUIET_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    setup_ack |-> (!coarse_tick && !cal_tick)) else $error("tick in setup"); // R4

  AST_COARSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_tick && cfg_rd[CMSB:P_COARSE_LSB] != '0) |=> !coarse_tick) else $error("coarse gap"); // R5

  AST_CAL_WITH_COARSE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_tick |-> coarse_tick) else $error("cal without coarse"); // R6

  AST_FINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_ack |-> (fine_count <= cfg_rd[P_FINE_W-1:0])) else $error("fine bound"); // R7
endmodule

bind cal_tick_prescaler cal_tick_prescaler_chk #(
  .P_CFG_W(P_CFG_W), .P_FINE_W(P_FINE_W), .P_COARSE_W(P_COARSE_W), .P_COARSE_LSB(P_COARSE_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .setup_ack(setup_ack), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
  .coarse_tick(coarse_tick), .cal_tick(cal_tick), .fine_count(fine_count)
);

// File: tb/cal_tick_prescaler_test.sv
module cal_tick_prescaler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setup_ack = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rd;
  logic        coarse_tick, cal_tick;
  logic [14:0] fine_count;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [31:0] m_cfg = 32'h007F_00FF;
  longint      m_k = 0;

  always #4 clk = ~clk;

  cal_tick_prescaler uut (
    .clk(clk), .rst_n(rst_n), .setup_ack(setup_ack), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .coarse_tick(coarse_tick),
    .cal_tick(cal_tick), .fine_count(fine_count)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: configuration word and elapsed count since setup exit
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cfg = 32'h007F_00FF;
      m_k = 0;
    end else if (setup_ack) begin
      if (cfg_wr) m_cfg = cfg_wdata & 32'h007F_7FFF;
      m_k = 0;
    end else begin
      m_k = m_k + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      longint a, s, p, et, es, ef;
      a = longint'(m_cfg[22:16]);
      s = longint'(m_cfg[14:0]);
      p = (a + 1) * (s + 1);
      check("R2 cfg_rd", cfg_rd, m_cfg);
      if (setup_ack) begin
        check("R4 coarse_tick in setup", coarse_tick, 0);
        check("R4 cal_tick in setup", cal_tick, 0);
      end else begin
        et = ((m_k % (a + 1)) == a) ? 1 : 0;
        es = ((m_k % p) == p - 1) ? 1 : 0;
        ef = s - ((m_k / (a + 1)) % (s + 1));
        check(a == 0 ? "R8 coarse_tick" : "R5 coarse_tick", coarse_tick, et);
        check(a == 0 ? "R8 cal_tick" : "R6 cal_tick", cal_tick, es);
        check("R7 fine_count", fine_count, ef);
      end
    end
  end

  task automatic step_n(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic setup_write(input logic [31:0] d);
    @(posedge clk); #1 setup_ack = 1'b1;
    step_n(2);
    cfg_wr = 1'b1; cfg_wdata = d;
    step_n(1);
    cfg_wr = 1'b0;
    step_n(2);
    setup_ack = 1'b0;
  endtask

  task automatic measure(input string req, input longint exp);
    longint n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cal_tick && n < 40000);
    check(req, n, exp);
  endtask

  initial begin
    step_n(3);
    check("R1 reset cfg_rd", cfg_rd, 32'h007F_00FF);
    check("R1 reset fine_count", fine_count, 255);
    rst_n = 1'b1;
    measure("R1 default period", 32768);
    step_n(5);
    // write ignored outside setup
    cfg_wr = 1'b1; cfg_wdata = 32'h0001_0001;
    step_n(1);
    cfg_wr = 1'b0;
    step_n(1);
    check("R2 ignored write", cfg_rd, 32'h007F_00FF);
    // reserved bits set in write data
    setup_write(32'hFF83_8004);
    check("R3 reserved masked", cfg_rd, 32'h0003_0004);
    step_n(100);
    setup_write(32'h0000_0002);
    step_n(30);
    setup_write(32'h0005_0000);
    step_n(40);
    // write in the last setup cycle
    @(posedge clk); #1 setup_ack = 1'b1;
    step_n(3);
    cfg_wr = 1'b1; cfg_wdata = 32'h0002_0003;
    step_n(1);
    cfg_wr = 1'b0; setup_ack = 1'b0;
    measure("R9 first period after last-cycle write", 12);
    step_n(50);
    setup_write(32'h0000_0000);
    step_n(10);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule